// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block takes a DDR SDRAM from power-on to a usable state. After reset it holds the clock-enable low for a programmable number of cycles. It then raises the clock-enable and issues a fixed series of commands with the required gaps between them: a precharge of every bank, a write to the extended mode register that turns the DLL on, and a mode register write that resets the DLL. A second precharge of every bank and a run of auto-refresh commands follow. The last command is a mode register write that clears the DLL-reset bit. All delays are counted in clock cycles and are set by parameters.

When the sequence is over, a ready flag passes the memory interface to the normal controller. A request for a clock-frequency change can arrive while the flag is high. The block then drops the flag and runs the DLL reset and lock wait again. It skips the long power-up hold and the extended register write. Its outputs are registered and drive the memory command pins directly. Whenever no step is issuing a command, the outputs carry a no-operation.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high, the outputs are: clock-enable low, command no-operation (cs_n,ras_n,cas_n,we_n = 0,1,1,1), bank and address zero, ready low.
- R2: After reset is released, the clock-enable stays low with no-operation on the command pins for PWRUP_CYC cycles. It first shows high in clock PWRUP_CYC+1 after release.
- R3: One cycle after the clock-enable rises, a precharge-all is issued. Its encoding is cs_n,ras_n,cas_n,we_n = 0,0,1,0 with address bit 10 high and bank zero.
- R4: T_RP cycles after that precharge, a mode register write (encoding 0,0,0,0) is issued with bank 1 and address EXT_WORD, whose bit 0 low enables the DLL.
- R5: T_MRD cycles later, a mode register write with bank 0 and address MODE_WORD with bit 8 set resets the DLL. T_MRD cycles after that, a second precharge-all is issued.
- R6: T_RP cycles after the second precharge, N_REFRESH auto-refresh commands (encoding 0,0,0,1, address zero) are issued, T_RFC cycles apart.
- R7: The final mode register write (bank 0, MODE_WORD with bit 8 cleared) comes at the later of two points: T_RFC cycles after the last refresh, or DLL_LOCK_CYC cycles after the DLL reset.
- R8: The ready flag rises T_MRD cycles after the final mode register write. It then stays high with no-operation on the command pins until a frequency-change request arrives.
- R9: A frequency-change request sampled while ready is high takes effect two cycles later: the ready flag is low and a precharge-all is on the pins. Then follow the DLL reset, the precharge, the refreshes and the final write, with the R5 to R8 spacing and lock rule. There is no power-up hold and no extended register write.
- R10: A frequency-change request while ready is low has no effect on the command sequence or its timing.
- R11: Once high, the clock-enable never returns low. No command other than a no-operation appears while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_chg_i | input | 1 | Request to redo the DLL reset after a clock-frequency change |
| cke_o | output | 1 | Clock-enable to the memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ADDR_W | Row/mode address lines |
| done_o | output | 1 | Initialization complete, controller may take over |

## Verification
The properties assume that the frequency-change request is synchronous to the clock. They assume T_MRD of at least two cycles and a DLL lock count of at least two. The property that links a falling ready flag to the request looks two cycles into the past. The stimulus drives the request only on falling edges and as single-cycle pulses. It pulses the request twice during the first run: once inside the power-up hold and once during the command phase. Both pulses must leave the expected event list untouched. It raises the request while ready is high only once, and never again before ready returns.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    ST_PWRUP,
    ST_CKE,
    ST_PRE1,
    ST_EMRS,
    ST_DLLRST,
    ST_PRE2,
    ST_REF,
    ST_LOCK,
    ST_FINAL,
    ST_DONE
  } step_t;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } cmd_t;

  localparam cmd_t CMD_NOP = 4'b0111;
  localparam cmd_t CMD_PRE = 4'b0010;
  localparam cmd_t CMD_REF = 4'b0001;
  localparam cmd_t CMD_MRS = 4'b0000;

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W   = 8,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= CNT_W'(RST_VAL);
    else if (load)         cnt <= load_val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_lock.sv
module ddr_init_lock #(
  parameter int LOCK_CYC = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic locked
);
  localparam int LIM = LOCK_CYC - 1;
  localparam int LW  = $clog2(LOCK_CYC + 1);

  logic [LW-1:0] lcnt;

  // lcnt equals the number of cycles elapsed since the DLL reset was issued
  always_ff @(posedge clk) begin
    if (rst)                       lcnt <= '0;
    else if (start)                lcnt <= LW'(1);
    else if (lcnt != LW'(LIM) && lcnt != '0) lcnt <= lcnt + 1'b1;
  end

  assign locked = (lcnt == LW'(LIM));

  // R7: the counter saturates and never runs past its limit
  p_lock_range_r7: assert property (@(posedge clk) disable iff (rst)
    lcnt <= LW'(LIM));

  // R7: lock indication, once reached, holds until a new DLL reset
  p_lock_held_r7: assert property (@(posedge clk) disable iff (rst)
    (locked && !start) |=> locked);
endmodule

// File: rtl/ddr_init_outreg.sv
module ddr_init_outreg
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BA_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cke_d,
  input  cmd_t              cmd_d,
  input  logic [BA_W-1:0]   ba_d,
  input  logic [ADDR_W-1:0] addr_d,
  input  logic              done_d,
  output logic              cke_q,
  output cmd_t              cmd_q,
  output logic [BA_W-1:0]   ba_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              done_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q  <= 1'b0;
      cmd_q  <= CMD_NOP;
      ba_q   <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      cke_q  <= cke_d;
      cmd_q  <= cmd_d;
      ba_q   <= ba_d;
      addr_q <= addr_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W       = 13,
  parameter int BA_W         = 2,
  parameter int PWRUP_CYC    = 40000,
  parameter int T_RP         = 5,
  parameter int T_RFC        = 17,
  parameter int T_MRD        = 2,
  parameter int DLL_LOCK_CYC = 200,
  parameter int N_REFRESH    = 2,
  parameter logic [ADDR_W-1:0] MODE_WORD = 'h032,
  parameter logic [ADDR_W-1:0] EXT_WORD  = 'h000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              freq_chg_i,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BA_W-1:0]   ba_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic              done_o
);
  localparam int AP_BIT      = 10;
  localparam int DLL_RST_BIT = 8;
  localparam int MAX_A  = (PWRUP_CYC > T_RFC) ? PWRUP_CYC : T_RFC;
  localparam int MAX_B  = (T_RP > T_MRD) ? T_RP : T_MRD;
  localparam int MAXGAP = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W  = $clog2(MAXGAP + 1);
  localparam int REF_W  = $clog2(N_REFRESH + 1);
  localparam logic [ADDR_W-1:0] DLL_BIT   = ADDR_W'(1) << DLL_RST_BIT;
  localparam logic [ADDR_W-1:0] MODE_RST  = MODE_WORD | DLL_BIT;
  localparam logic [ADDR_W-1:0] MODE_RUN  = MODE_WORD & ~DLL_BIT;
  localparam logic [ADDR_W-1:0] PRE_ALL   = ADDR_W'(1) << AP_BIT;

  step_t            st, st_n;
  logic             fresh, relock;
  logic [REF_W-1:0] refcnt;
  logic             expired, locked, adv;
  logic [CNT_W-1:0] ld_val;

  cmd_t              cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;
  cmd_t              cmd_q;

  function automatic logic [CNT_W-1:0] gap_m1(step_t s);
    case (s)
      ST_PWRUP:          gap_m1 = CNT_W'(PWRUP_CYC - 1);
      ST_PRE1, ST_PRE2:  gap_m1 = CNT_W'(T_RP - 1);
      ST_EMRS, ST_DLLRST,
      ST_FINAL:          gap_m1 = CNT_W'(T_MRD - 1);
      ST_REF:            gap_m1 = CNT_W'(T_RFC - 1);
      default:           gap_m1 = '0;
    endcase
  endfunction

  // step advance: the gap of a step is loaded when it is entered
  always_comb begin
    st_n = st;
    case (st)
      ST_PWRUP:  if (expired) st_n = ST_CKE;
      ST_CKE:    if (expired) st_n = ST_PRE1;
      ST_PRE1:   if (expired) st_n = relock ? ST_DLLRST : ST_EMRS;
      ST_EMRS:   if (expired) st_n = ST_DLLRST;
      ST_DLLRST: if (expired) st_n = ST_PRE2;
      ST_PRE2:   if (expired) st_n = ST_REF;
      ST_REF:    if (expired) begin
                   if (refcnt == REF_W'(N_REFRESH - 1))
                     st_n = locked ? ST_FINAL : ST_LOCK;
                   else
                     st_n = ST_REF;
                 end
      ST_LOCK:   if (locked) st_n = ST_FINAL;
      ST_FINAL:  if (expired) st_n = ST_DONE;
      ST_DONE:   if (freq_chg_i) st_n = ST_PRE1;
      default:   st_n = ST_PWRUP;
    endcase
    adv = (st_n != st) || (st == ST_REF && expired);
    ld_val = gap_m1(st_n);
  end

  // command of the current step, driven only on its first cycle
  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (fresh) begin
      case (st)
        ST_PRE1, ST_PRE2: begin cmd_d = CMD_PRE; addr_d = PRE_ALL;  end
        ST_EMRS:   begin cmd_d = CMD_MRS; ba_d = BA_W'(1); addr_d = EXT_WORD; end
        ST_DLLRST: begin cmd_d = CMD_MRS; addr_d = MODE_RST; end
        ST_REF:    cmd_d = CMD_REF;
        ST_FINAL:  begin cmd_d = CMD_MRS; addr_d = MODE_RUN; end
        default:   cmd_d = CMD_NOP;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_PWRUP;
      fresh  <= 1'b1;
      refcnt <= '0;
      relock <= 1'b0;
    end else begin
      fresh <= adv;
      if (adv) st <= st_n;
      if (adv && st == ST_PRE2)            refcnt <= '0;
      else if (adv && st == ST_REF)        refcnt <= refcnt + 1'b1;
      if (st == ST_DONE && freq_chg_i)     relock <= 1'b1;
      else if (st == ST_FINAL)             relock <= 1'b0;
    end
  end

  ddr_init_timer #(.CNT_W(CNT_W), .RST_VAL(PWRUP_CYC - 1)) u_timer (
    .clk(clk), .rst(rst), .load(adv), .load_val(ld_val), .expired(expired)
  );

  ddr_init_lock #(.LOCK_CYC(DLL_LOCK_CYC)) u_lock (
    .clk(clk), .rst(rst), .start(fresh && st == ST_DLLRST), .locked(locked)
  );

  ddr_init_outreg #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_out (
    .clk(clk), .rst(rst),
    .cke_d(st != ST_PWRUP), .cmd_d(cmd_d), .ba_d(ba_d), .addr_d(addr_d),
    .done_d(st == ST_DONE),
    .cke_q(cke_o), .cmd_q(cmd_q), .ba_q(ba_o), .addr_q(addr_o), .done_q(done_o)
  );

  assign cs_n_o  = cmd_q.cs_n;
  assign ras_n_o = cmd_q.ras_n;
  assign cas_n_o = cmd_q.cas_n;
  assign we_n_o  = cmd_q.we_n;

  // R11: clock-enable never drops once raised
  p_cke_hold_r11: assert property (@(posedge clk) disable iff (rst)
    cke_o |=> cke_o);

  // R11: no real command while the clock-enable is low
  p_cmd_needs_cke_r11: assert property (@(posedge clk) disable iff (rst)
    (!cke_o) |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

  // R8: the pins stay quiet while ready is shown
  p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));

  // R9: ready only falls two cycles after a frequency-change request
  p_done_fall_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(done_o) |-> $past(freq_chg_i, 2));

  generate
    if (T_MRD >= 2) begin : g_mrd
      // R5: a mode register write is followed by a no-operation
      p_mrs_gap_r5: assert property (@(posedge clk) disable iff (rst)
        ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0000) |=>
        ({cs_n_o, ras_n_o, cas_n_o, we_n_o} == 4'b0111));
    end
  endgenerate
endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_test;
  localparam int P = 50, RP = 3, RFC = 5, MRD = 2, LCK = 30, NREF = 2;
  localparam int EV_CKE = 0, EV_PRE = 1, EV_REF = 2, EV_MRS = 3,
                 EV_DUP = 4, EV_DDN = 5, EV_BAD = 7;

  logic clk = 0, rst = 1, freq = 0;
  logic cke, cs_n, ras_n, cas_n, we_n, done;
  logic [1:0]  ba;
  logic [12:0] addr;
  int checks = 0, errors = 0, edges = 0, last_ev = 0;
  logic prev_cke = 0, prev_done = 0;

  typedef struct { int kind; int ba; int addr; int gap; string req; } ev_t;
  ev_t q[$];

  always #2.5 clk = ~clk;

  ddr_init_seq #(.PWRUP_CYC(P), .T_RP(RP), .T_RFC(RFC), .T_MRD(MRD),
    .DLL_LOCK_CYC(LCK), .N_REFRESH(NREF), .MODE_WORD(13'h032),
    .EXT_WORD(13'h002)) uut (
    .clk(clk), .rst(rst), .freq_chg_i(freq), .cke_o(cke), .cs_n_o(cs_n),
    .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .ba_o(ba),
    .addr_o(addr), .done_o(done));

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(int k, int b, int a, int g, string r);
    ev_t e;
    e.kind = k; e.ba = b; e.addr = a; e.gap = g; e.req = r;
    q.push_back(e);
  endtask

  // dll reset, precharge, refreshes, final write, ready
  task automatic push_tail();
    int before_fin;
    before_fin = MRD + RP + (NREF - 1) * RFC;
    push(EV_MRS, 0, 'h132, MRD, "R5");
    push(EV_PRE, 0, 'h400, MRD, "R5");
    push(EV_REF, 0, 0, RP, "R6");
    for (int i = 1; i < NREF; i++) push(EV_REF, 0, 0, RFC, "R6");
    push(EV_MRS, 0, 'h032, (RFC > LCK - before_fin) ? RFC : LCK - before_fin, "R7");
    push(EV_DUP, 0, 0, MRD, "R8");
  endtask

  always @(posedge clk) if (rst) edges <= 0; else edges <= edges + 1;

  task automatic take(int k, int b, int a);
    ev_t e;
    if (q.size() == 0) begin
      check(0, "R10", k, -1);
    end else begin
      e = q.pop_front();
      check(e.kind == k && e.ba == b && e.addr == a &&
            (e.gap < 0 || e.gap == edges - last_ev),
            e.req, (k << 24) | (b << 20) | (a << 8) | ((edges - last_ev) & 'hff),
            (e.kind << 24) | (e.ba << 20) | (e.addr << 8) | (e.gap & 'hff));
    end
    last_ev = edges;
  endtask

  // monitor: detect events away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (cke && !prev_cke) take(EV_CKE, 0, 0);
      if (!done && prev_done) take(EV_DDN, 0, 0);
      if (!cs_n && {ras_n, cas_n, we_n} != 3'b111) begin
        case ({ras_n, cas_n, we_n})
          3'b010:  take(EV_PRE, ba, addr);
          3'b001:  take(EV_REF, ba, addr);
          3'b000:  take(EV_MRS, ba, addr);
          default: take(EV_BAD, ba, addr);
        endcase
      end
      if (done && !prev_done) take(EV_DUP, 0, 0);
      prev_cke = cke;
      prev_done = done;
    end
  end

  task automatic pulse_freq();
    @(negedge clk) freq = 1;
    @(negedge clk) freq = 0;
  endtask

  task automatic run_main();
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cke == 0, "R1", cke, 0);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1", {cs_n, ras_n, cas_n, we_n}, 7);
    check(ba == 0 && addr == 0, "R1", addr, 0);
    check(done == 0, "R1", done, 0);
    push(EV_CKE, 0, 0, P + 1, "R2");
    push(EV_PRE, 0, 'h400, 1, "R3");
    push(EV_MRS, 1, 'h002, RP, "R4");
    push_tail();
    rst = 0;
    repeat (20) @(negedge clk);
    pulse_freq();                            // R10: inside power-up hold
    wait (edges >= P + 8);
    pulse_freq();                            // R10: during command phase
    wait (done);
    repeat (10) @(negedge clk);
    check(done == 1 && cke == 1, "R8", {cke, done}, 3);
    check({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R8", {cs_n, ras_n, cas_n, we_n}, 7);
    check(q.size() == 0, "R10", q.size(), 0);
    // R9: frequency change while ready
    push(EV_DDN, 0, 0, -1, "R9");
    push(EV_PRE, 0, 'h400, 0, "R9");
    push(EV_MRS, 0, 'h132, RP, "R9");
    push(EV_PRE, 0, 'h400, MRD, "R9");
    push(EV_REF, 0, 0, RP, "R9");
    for (int i = 1; i < NREF; i++) push(EV_REF, 0, 0, RFC, "R9");
    push(EV_MRS, 0, 'h032, (RFC > LCK - (MRD + RP + (NREF - 1) * RFC)) ?
         RFC : LCK - (MRD + RP + (NREF - 1) * RFC), "R9");
    push(EV_DUP, 0, 0, MRD, "R9");
    @(negedge clk) freq = 1;
    @(negedge clk) freq = 0;
    check(done == 1, "R9", done, 1);
    @(negedge clk);
    check(done == 0, "R9", done, 0);
    wait (done);
    repeat (5) @(negedge clk);
    check(q.size() == 0, "R9", q.size(), 0);
    check(cke == 1, "R11", cke, 1);
  endtask

  initial begin
    fork
      run_main();
      begin
        repeat (5000) @(posedge clk);
        check(0, "watchdog", edges, 0);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule